// File: doc/BRIEF.md
# Twin-Predicated Element Step Sequencer

This block drives the element loop of a vector operation in which source and destination share one predicate mask but each side has its own zeroing flag. A single start pulse loads the vector length, the mask and the two flags. The block then hands out one pair of element indices on each accepted cycle: a source index and a destination index. Each pair comes with a flag that tells the consumer to write zero instead of the operation result.

Each side keeps its own counter. A side whose zeroing flag is clear moves straight to the next position whose mask bit is 1. A side whose zeroing flag is set walks every position in order. Because of this the two counters can drift apart. The loop stops as soon as either side has no further position below the vector length, and `done_o` reports the end of the loop. The consumer throttles the sequence with `ready_i`.

Top module: `step_seq`

## Requirements
- R1: After reset, `valid_o` and `done_o` are both 0.
- R2: A side whose zeroing flag is 0 only produces indices whose mask bit is 1. Bit i of `mask_i` belongs to element i. Each such index is the lowest qualifying position above the previous index on that side, starting from element 0.
- R3: A side whose zeroing flag is 1 produces 0, 1, 2, ... in order and ignores the mask. For example, with mask bits 0..3 = 1,0,1,1 and VL=4: with src flag 1 and dst flag 0 the pairs are (0,0),(1,2),(2,3); with src flag 0 and dst flag 1 the pairs are (0,0),(2,1),(3,2).
- R4: The loop ends when either side has no qualifying position below VL. `valid_o` then falls and `done_o` rises in the same cycle. `done_o` stays 1 until the next accepted start.
- R5: `dst_zero_o` is 1 for an emitted pair exactly when the dst flag is 1 and the mask bit at the destination index is 0.
- R6: While `valid_o` is 1 and `ready_i` is 0, the pair, `dst_zero_o` and `valid_o` stay unchanged.
- R7: A start with VL=0, or with no qualifying position on one side, emits no pair. In that case `done_o` is 1 in the cycle after the start.
- R8: `start_i` has no effect while a loop is running. The running sequence continues unchanged.
- R9: The first pair is valid in the cycle after the start. Each accepted pair is followed in the very next cycle by the next pair or by the end of the loop, however many mask bits are skipped.
- R10: With both flags 0, the source and destination indices are equal on every pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the parameters below and begin a loop (taken only when idle) |
| vl_i | input | VLW | Vector length, 0..MAX_VL |
| mask_i | input | MAX_VL | Predicate mask; bit i belongs to element i |
| src_zeroing_i | input | 1 | Source zeroing flag |
| dst_zeroing_i | input | 1 | Destination zeroing flag |
| ready_i | input | 1 | Consumer accepts the current pair |
| valid_o | output | 1 | A pair is presented |
| src_step_o | output | IW | Source element index |
| dst_step_o | output | IW | Destination element index |
| dst_zero_o | output | 1 | Write zero to this destination element |
| done_o | output | 1 | Loop has ended |

## Verification
The hardest case to reach is a loop that ends on one side while the other side still has positions left. Mask patterns with differing flags reach it, because one counter drifts ahead of the other. A long mask with sparse set bits near the top element exercises the skip distance, and a stalled run with a start pulse injected mid-loop checks that the held pair cannot be disturbed. The bench computes every expected pair stream with its own step-by-step model of the two counters.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  typedef enum logic {
    SIDE_SRC = 1'b0,
    SIDE_DST = 1'b1
  } side_e;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/step_finder.sv
// Lowest qualifying element at or above from_i and below vl_i.
module step_finder #(
  parameter int MAX_VL = 64,
  parameter int IW     = $clog2(MAX_VL),
  parameter int VLW    = IW + 1
) (
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [VLW-1:0]    from_i,
  input  logic              zeroing_i,
  output logic              found_o,
  output logic [IW-1:0]     idx_o
);
  logic [MAX_VL-1:0] cand;

  always_comb begin
    for (int i = 0; i < MAX_VL; i++) begin
      cand[i] = (VLW'(i) >= from_i) && (VLW'(i) < vl_i) && (zeroing_i || mask_i[i]);
    end
  end

  // downward scan: lowest candidate wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/step_seq_ctrl.sv
module step_seq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  input  logic found_all_i,
  output logic accept_o,
  output logic load_o,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, done_q;

  assign accept_o = start_i & ~busy_q;
  assign load_o   = accept_o | (busy_q & ready_i);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_o) begin
      busy_q <= found_all_i;
      done_q <= ~found_all_i;
    end
  end
endmodule

// File: rtl/step_seq.sv
module step_seq
  import step_seq_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IW     = $clog2(MAX_VL),
  parameter int VLW    = IW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic              src_zeroing_i,
  input  logic              dst_zeroing_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [IW-1:0]     src_step_o,
  output logic [IW-1:0]     dst_step_o,
  output logic              dst_zero_o,
  output logic              done_o
);
  logic [MAX_VL-1:0]           mask_q, mask_eff;
  logic [VLW-1:0]              vl_q, vl_eff;
  logic [NUM_SIDES-1:0]        zq_q, zin, z_eff;
  logic [NUM_SIDES-1:0][IW-1:0] step_q, step_nx;
  logic [NUM_SIDES-1:0]        found;
  logic                        accept, load, busy;
  logic                        src_zq, dst_zq;

  assign zin      = {dst_zeroing_i, src_zeroing_i};
  assign mask_eff = accept ? mask_i : mask_q;
  assign vl_eff   = accept ? vl_i : vl_q;
  assign z_eff    = accept ? zin : zq_q;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic [VLW-1:0] from;
    // restart from element 0 on a new loop, else one past the current step
    assign from = accept ? '0 : ({1'b0, step_q[s]} + VLW'(1));

    step_finder #(.MAX_VL(MAX_VL), .IW(IW), .VLW(VLW)) u_find (
      .mask_i   (mask_eff),
      .vl_i     (vl_eff),
      .from_i   (from),
      .zeroing_i(z_eff[s]),
      .found_o  (found[s]),
      .idx_o    (step_nx[s])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   step_q[s] <= '0;
      else if (load) step_q[s] <= step_nx[s];
    end
  end

  step_seq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ready_i    (ready_i),
    .found_all_i(&found),
    .accept_o   (accept),
    .load_o     (load),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      vl_q   <= '0;
      zq_q   <= '0;
    end else if (accept) begin
      mask_q <= mask_i;
      vl_q   <= vl_i;
      zq_q   <= zin;
    end
  end

  assign src_zq     = zq_q[SIDE_SRC];
  assign dst_zq     = zq_q[SIDE_DST];
  assign valid_o    = busy;
  assign src_step_o = step_q[SIDE_SRC];
  assign dst_step_o = step_q[SIDE_DST];
  assign dst_zero_o = busy & dst_zq & ~mask_q[step_q[SIDE_DST]];
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
  parameter int IW  = 6,
  parameter int VLW = IW + 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           ready_i,
  input logic           valid_o,
  input logic [IW-1:0]  src_step_o,
  input logic [IW-1:0]  dst_step_o,
  input logic           dst_zero_o,
  input logic           done_o,
  input logic [VLW-1:0] vl_q,
  input logic           src_zq,
  input logic           dst_zq
);
  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(src_step_o) && $stable(dst_step_o) && $stable(dst_zero_o));
  // R4
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !done_o);
  // R2
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({1'b0, src_step_o} < vl_q) && ({1'b0, dst_step_o} < vl_q));
  // R10
  lockstep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !src_zq && !dst_zq |-> src_step_o == dst_step_o);
  // R5
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_zero_o |-> valid_o && dst_zq);
  // R9
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i |=> !valid_o || (src_step_o > $past(src_step_o) && dst_step_o > $past(dst_step_o)));
  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && start_i && !ready_i |=> valid_o && $stable(done_o));
endmodule

bind step_seq step_seq_chk #(.IW(IW), .VLW(VLW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ready_i   (ready_i),
  .valid_o   (valid_o),
  .src_step_o(src_step_o),
  .dst_step_o(dst_step_o),
  .dst_zero_o(dst_zero_o),
  .done_o    (done_o),
  .vl_q      (vl_q),
  .src_zq    (src_zq),
  .dst_zq    (dst_zq)
);

// File: tb/sim_step_seq.sv
module sim_step_seq;
  localparam int MAX_VL = 64;
  localparam int IW     = 6;
  localparam int VLW    = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [VLW-1:0]    vl_i = '0;
  logic [MAX_VL-1:0] mask_i = '0;
  logic              src_zeroing_i = 1'b0;
  logic              dst_zeroing_i = 1'b0;
  logic              ready_i = 1'b0;
  logic              valid_o, dst_zero_o, done_o;
  logic [IW-1:0]     src_step_o, dst_step_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  int exp_s[MAX_VL + 1];
  int exp_d[MAX_VL + 1];
  bit exp_z[MAX_VL + 1];
  int n_exp;

  always #10 clk_i = ~clk_i;  // 50 MHz

  step_seq #(.MAX_VL(MAX_VL), .IW(IW), .VLW(VLW)) u0 (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected < 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt(input logic [MAX_VL-1:0] m, input int vl, input bit z, input int from);
    int i = from;
    while (i < vl && !z && !m[i]) i++;
    return i;
  endfunction

  task automatic build(input int vl, input logic [MAX_VL-1:0] m, input bit sz, input bit dz);
    int s = nxt(m, vl, sz, 0);
    int d = nxt(m, vl, dz, 0);
    n_exp = 0;
    while (s < vl && d < vl) begin
      exp_s[n_exp] = s; exp_d[n_exp] = d; exp_z[n_exp] = dz && !m[d];
      n_exp++;
      s = nxt(m, vl, sz, s + 1);
      d = nxt(m, vl, dz, d + 1);
    end
  endtask

  // One scenario: start, collect pairs under an optional stall pattern, compare.
  task automatic run_case(input string req, input int vl, input logic [MAX_VL-1:0] m,
                          input bit sz, input bit dz, input bit stall, input bit poke);
    int k = 0;
    bit held = 0;
    int ps = 0, pd = 0;
    bit pz = 0;
    build(vl, m, sz, dz);
    @(negedge clk_i);
    start_i = 1; vl_i = VLW'(vl); mask_i = m;
    src_zeroing_i = sz; dst_zeroing_i = dz; ready_i = 0;
    @(negedge clk_i);
    start_i = 0;
    for (int c = 0; c < 400; c++) begin
      if (done_o) break;
      // R8: start pulse while busy, with parameters that would end the loop
      if (poke && c == 1) begin
        start_i = 1; vl_i = '0;
      end else begin
        start_i = 0;
      end
      if (!valid_o) begin
        chk(0, "R9", "bubble valid_o", 0, 1);
        break;
      end
      if (held) begin
        chk(src_step_o == ps && dst_step_o == pd && dst_zero_o == pz, "R6",
            "stalled pair moved src", src_step_o, ps);
      end
      ready_i = !stall || (c % 3 != 1);
      if (ready_i) begin
        if (k < n_exp) begin
          chk(src_step_o == exp_s[k], req, $sformatf("src pair %0d", k), src_step_o, exp_s[k]);
          chk(dst_step_o == exp_d[k], req, $sformatf("dst pair %0d", k), dst_step_o, exp_d[k]);
          chk(dst_zero_o == exp_z[k], "R5", $sformatf("zero flag pair %0d", k), dst_zero_o, exp_z[k]);
        end else begin
          chk(0, "R4", "pair beyond end", k, n_exp);
        end
        k++;
      end
      held = !ready_i;
      ps = src_step_o; pd = dst_step_o; pz = dst_zero_o;
      @(negedge clk_i);
    end
    start_i = 0;
    ready_i = 0;
    chk(k == n_exp, "R4", $sformatf("%s pair count", req), k, n_exp);
    chk(done_o == 1 && valid_o == 0, "R4", "done at end", done_o, 1);
  endtask

  initial begin
    logic [MAX_VL-1:0] sparse;
    sparse = '0;
    sparse[5] = 1; sparse[40] = 1; sparse[63] = 1;

    repeat (3) @(negedge clk_i);
    chk(valid_o == 0 && done_o == 0, "R1", "reset outputs", {valid_o, done_o}, 0);
    rst_ni = 1;

    // R3: src zeroing, dst skipping, mask 1,0,1,1
    run_case("R3", 4, 64'b1101, 1, 0, 0, 0);
    chk(n_exp == 3 && exp_s[1] == 1 && exp_d[1] == 2, "R3", "model ex1", exp_d[1], 2);
    // R3: src skipping, dst zeroing
    run_case("R3", 4, 64'b1101, 0, 1, 0, 0);
    // R10: both skipping, lockstep
    run_case("R10", 16, 64'hA5C3, 0, 0, 0, 0);
    // R2: sparse mask over the full length, both sides skip long runs
    run_case("R2", 64, sparse, 0, 0, 0, 0);
    // R3/R5: both zeroing, every element, zero flag on masked-out ones
    run_case("R3", 8, 64'b1001_0110, 1, 1, 0, 0);
    // R6: stalls on a drifting run
    run_case("R6", 12, 64'hB3D, 1, 0, 1, 0);
    // R8: start ignored while busy
    run_case("R8", 4, 64'b1101, 1, 0, 1, 1);
    // R7: VL zero
    run_case("R7", 0, 64'hFF, 0, 0, 0, 0);
    // R7: no set bit on a skipping side
    run_case("R7", 10, 64'h0, 1, 0, 0, 0);
    // R9: run after done; done must clear and pairs follow back to back
    run_case("R9", 64, {32{2'b10}}, 0, 1, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule